// File: doc/BRIEF.md
# Programmable Chip-Select Decoder

This block turns a 24-bit bus address and the attributes of the current bus cycle into a set of active-low select lines, one per channel. Each channel is set up by two 16-bit configuration words. The base word places a power-of-two address window on a 2K boundary. The option word says which byte lanes, which transfer direction and which address space the channel answers. It also says which strobe times the select, how long the cycle waits before it is acknowledged, and how interrupt-acknowledge cycles are treated.

On top of the selects, the block produces an internal cycle-termination acknowledge. It raises this after the programmed number of wait clocks, counted from the address strobe, and holds it until the strobe returns high. For interrupt-acknowledge cycles that hit a channel with autovectoring enabled, it also produces an autovector request. The configuration words arrive as plain inputs from whatever register file the surrounding chip provides.

Top module: `csel_bank`

## Requirements
- R1: A channel's base word bits 15:3 give address bits 23:11 of its window. Bits 2:0 choose the window size: 0=2K, 1=8K, 2=16K, 3=64K, 4=128K, 5=256K, 6=512K, 7=1M. Only address bits above the window size are compared.
- R2: A channel whose option word is all zeros never asserts its select.
- R3: Option bits 14:13 qualify byte lanes: 01 answers when the lower lane is active, 10 when the upper lane is active, 11 when either lane is active, and 00 never.
- R4: Option bits 12:11 qualify direction (rd_wr=1 is a read): 01 read only, 10 write only, 11 both, 00 never.
- R5: Option bit 10 chooses the select timing. With 0 the select follows the address strobe (as_n low). With 1 it follows the data strobe (ds_n low).
- R6: Option bits 9:6 hold a wait code from 0 to 13. For wait code n, dsack_n goes low at the (n+1)-th rising clock edge that samples as_n low. It stays low while as_n stays low and returns high as soon as as_n goes high.
- R7: Wait code 14 is fast termination: dsack_n goes low in the same cycle as as_n, with no clock edge between them.
- R8: Wait code 15 leaves termination to an external source: the select still asserts, but dsack_n stays high.
- R9: Option bits 5:4 choose the address space. 00 is CPU space, 01 user, 10 supervisor, 11 user or supervisor. These compare against the cycle's space input: 00 CPU, 01 user, 10 supervisor.
- R10: In CPU space, option bits 3:1 give an interrupt level that must equal addr[3:1]; 0 matches any level. When the acknowledging channel is a CPU-space channel with option bit 0 set, avec_n goes low while as_n is low.
- R11: When several channels match, all of their selects assert, and dsack_n timing follows the lowest-numbered matching channel.
- R12: Under reset, with both strobes high, all selects, dsack_n and avec_n are high, and the wait counters restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_cfg | input | 16*NUM_CH | Base words, channel i in bits 16i+15:16i |
| opt_cfg | input | 16*NUM_CH | Option words, channel i in bits 16i+15:16i |
| addr | input | 24 | Bus address |
| rd_wr | input | 1 | 1 = read cycle, 0 = write cycle |
| upper_en | input | 1 | Upper byte lane active in this cycle |
| lower_en | input | 1 | Lower byte lane active in this cycle |
| space | input | 2 | Cycle space: 00 CPU, 01 user, 10 supervisor |
| as_n | input | 1 | Address strobe, active low |
| ds_n | input | 1 | Data strobe, active low |
| cs_n | output | NUM_CH | Channel selects, active low |
| dsack_n | output | 1 | Internal cycle acknowledge, active low |
| avec_n | output | 1 | Autovector request, active low |

## Verification
The assertions check on every cycle that dsack_n and avec_n are low only inside an address strobe, and that dsack_n never appears without some channel matching. They also check that once dsack_n is given it stays low for the rest of a stable strobe, that no select asserts without a strobe, and that a disabled channel's select stays high. Only the bench's scenarios can show the exact decode results: window sizes and edges, the lane, direction, space and level filters, the precise edge count for each wait code, fast and external termination, and the lowest-channel rule for acknowledge timing.

// File: rtl/csel_pkg.sv
// Package csel_pkg: shared types and helpers for the chip-select bank.
// Assumes a 24-bit address bus and 16-bit configuration words.
package csel_pkg;

    localparam int ADDR_W   = 24;
    localparam int CFG_W    = 16;
    localparam int WAIT_W   = 4;
    localparam int BASE_LSB = 11;

    localparam logic [WAIT_W-1:0] WAIT_LAST = 4'd13;
    localparam logic [WAIT_W-1:0] WAIT_FAST = 4'd14;

    // Option word layout, most significant field first
    typedef struct packed {
        logic              mode;
        logic [1:0]        lane;
        logic [1:0]        dir;
        logic              ds_sync;
        logic [WAIT_W-1:0] waits;
        logic [1:0]        space;
        logic [2:0]        ipl;
        logic              avec;
    } csel_opt_t;

    // Lowest compared address bit for a window-size code
    function automatic int unsigned size_lsb(input logic [2:0] code);
        case (code)
            3'd0:    return 11;
            3'd1:    return 13;
            3'd2:    return 14;
            3'd3:    return 16;
            3'd4:    return 17;
            3'd5:    return 18;
            3'd6:    return 19;
            default: return 20;
        endcase
    endfunction

    // Mask of the address bits compared for a window-size code
    function automatic logic [ADDR_W-1:0] size_mask(input logic [2:0] code);
        logic [ADDR_W-1:0] m;
        for (int b = 0; b < ADDR_W; b++) begin
            m[b] = (b >= int'(size_lsb(code)));
        end
        return m;
    endfunction

endpackage

// File: rtl/csel_match.sv
// Module csel_match: attribute and address compare for one channel.
// Purely combinational; the result is not gated by any strobe.
// Assumes the space input uses 00=CPU, 01=user, 10=supervisor.
module csel_match
    import csel_pkg::*;
(
    input  logic [CFG_W-1:0]  base_w,
    input  csel_opt_t         opt_w,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_wr,
    input  logic              upper_en,
    input  logic              lower_en,
    input  logic [1:0]        space,
    output logic              match
);

    logic [ADDR_W-1:0] base_addr;
    logic [ADDR_W-1:0] mask;
    logic              enabled;
    logic              addr_ok;
    logic              lane_ok;
    logic              dir_ok;
    logic              space_ok;
    logic              level_ok;

    // Window base and compare mask from the base word
    always_comb begin
        base_addr = {base_w[CFG_W-1:3], {BASE_LSB{1'b0}}};
        mask      = size_mask(base_w[2:0]);
        addr_ok   = ((addr ^ base_addr) & mask) == '0;
    end

    // Cycle attribute qualification from the option word
    always_comb begin
        enabled  = opt_w != '0;
        lane_ok  = (opt_w.lane[1] & upper_en) | (opt_w.lane[0] & lower_en);
        dir_ok   = rd_wr ? opt_w.dir[0] : opt_w.dir[1];
        if (opt_w.space == 2'b00) begin
            space_ok = (space == 2'b00);
            level_ok = (opt_w.ipl == 3'd0) || (opt_w.ipl == addr[3:1]);
        end else begin
            space_ok = (space != 2'b00) &&
                       ((opt_w.space == 2'b11) || (opt_w.space == space));
            level_ok = 1'b1;
        end
        match = enabled & addr_ok & lane_ok & dir_ok & space_ok & level_ok;
    end

endmodule

// File: rtl/csel_wait.sv
// Module csel_wait: wait-state counter and acknowledge for one channel.
// Assumes hit is the channel match already gated by the address strobe,
// and that it stays high for the whole strobe.
module csel_wait
    import csel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic [WAIT_W-1:0] waits,
    output logic              ack
);

    logic [WAIT_W-1:0] cnt_q;
    logic              ack_q;
    logic              fast;

    // Count strobe clocks and latch the acknowledge once the count is reached
    always_ff @(posedge clk) begin
        if (!rst_n || !hit) begin
            cnt_q <= '0;
            ack_q <= 1'b0;
        end else begin
            if (cnt_q != '1) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (waits <= WAIT_LAST && cnt_q >= waits) begin
                ack_q <= 1'b1;
            end
        end
    end

    // Fast code acknowledges at once; the latched ack lasts only while hit
    always_comb begin
        fast = (waits == WAIT_FAST);
        ack  = hit & (ack_q | fast);
    end

endmodule

// File: rtl/csel_bank.sv
// Module csel_bank: bank of programmable chip-select channels.
// Drives one active-low select per channel and the internal acknowledge
// and autovector of the lowest-numbered matching channel.
// Assumes the configuration words stay stable during a bus cycle.
module csel_bank
    import csel_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CH*CFG_W-1:0] base_cfg,
    input  logic [NUM_CH*CFG_W-1:0] opt_cfg,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    rd_wr,
    input  logic                    upper_en,
    input  logic                    lower_en,
    input  logic [1:0]              space,
    input  logic                    as_n,
    input  logic                    ds_n,
    output logic [NUM_CH-1:0]       cs_n,
    output logic                    dsack_n,
    output logic                    avec_n
);

    logic [NUM_CH-1:0] match_vec;
    logic [NUM_CH-1:0] hit_vec;
    logic [NUM_CH-1:0] ack_vec;
    logic [NUM_CH-1:0] avec_vec;
    logic [NUM_CH-1:0] owner;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        csel_opt_t opt_i;

        // Unpack this channel's option word
        always_comb opt_i = csel_opt_t'(opt_cfg[i*CFG_W +: CFG_W]);

        csel_match u_match (
            .base_w   (base_cfg[i*CFG_W +: CFG_W]),
            .opt_w    (opt_i),
            .addr     (addr),
            .rd_wr    (rd_wr),
            .upper_en (upper_en),
            .lower_en (lower_en),
            .space    (space),
            .match    (match_vec[i])
        );

        // Strobe gating of the select and of the acknowledge hit
        always_comb begin
            cs_n[i]     = ~(match_vec[i] & (opt_i.ds_sync ? ~ds_n : ~as_n));
            hit_vec[i]  = match_vec[i] & ~as_n;
            avec_vec[i] = (opt_i.space == 2'b00) & opt_i.avec;
        end

        csel_wait u_wait (
            .clk   (clk),
            .rst_n (rst_n),
            .hit   (hit_vec[i]),
            .waits (opt_i.waits),
            .ack   (ack_vec[i])
        );
    end

    // Lowest-numbered hit owns the acknowledge and autovector
    always_comb begin
        owner   = hit_vec & (~hit_vec + 1'b1);
        dsack_n = ~|(owner & ack_vec);
        avec_n  = ~|(owner & avec_vec);
    end

endmodule

// File: rtl/csel_bank_chk.sv
// Module csel_bank_chk: property checker for csel_bank, bound below.
// Assumes configuration words are held stable across bus cycles.
module csel_bank_chk
    import csel_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    as_n,
    input logic                    ds_n,
    input logic [NUM_CH*CFG_W-1:0] opt_cfg,
    input logic [NUM_CH-1:0]       hit_vec,
    input logic [NUM_CH-1:0]       cs_n,
    input logic                    dsack_n,
    input logic                    avec_n
);

    // R6: acknowledge only inside an address strobe
    p_ack_in_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !dsack_n |-> !as_n);

    // R6: acknowledge, once given, holds for the rest of a stable strobe
    p_ack_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!dsack_n) && $past(!as_n) && !as_n &&
         $stable(opt_cfg) && $stable(hit_vec)) |-> !dsack_n);

    // R5: no select without one of the strobes
    p_sel_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n != '1) |-> (!as_n || !ds_n));

    // R11: acknowledge requires some matching channel
    p_ack_has_hit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !dsack_n |-> (hit_vec != '0));

    // R10: autovector only inside an address strobe
    p_avec_in_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !avec_n |-> !as_n);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_off
        // R2: an all-zero option word keeps the select high
        p_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (opt_cfg[i*CFG_W +: CFG_W] == '0) |-> cs_n[i]);
    end

endmodule

bind csel_bank csel_bank_chk #(.NUM_CH(NUM_CH)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .as_n    (as_n),
    .ds_n    (ds_n),
    .opt_cfg (opt_cfg),
    .hit_vec (hit_vec),
    .cs_n    (cs_n),
    .dsack_n (dsack_n),
    .avec_n  (avec_n)
);

// File: tb/csel_bank_tb_top.sv
// Directed bench for csel_bank: one task per scenario, each self-checking.
module csel_bank_tb_top;

    localparam int NCH = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [15:0]       bcfg [NCH];
    logic [15:0]       ocfg [NCH];
    logic [NCH*16-1:0] base_cfg;
    logic [NCH*16-1:0] opt_cfg;
    logic [23:0]       addr = '0;
    logic              rd_wr = 1'b1;
    logic              upper_en = 1'b1;
    logic              lower_en = 1'b1;
    logic [1:0]        space = 2'b10;
    logic              as_n = 1'b1;
    logic              ds_n = 1'b1;
    logic [NCH-1:0]    cs_n;
    logic              dsack_n;
    logic              avec_n;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    // Pack the per-channel words onto the flat ports
    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            base_cfg[i*16 +: 16] = bcfg[i];
            opt_cfg[i*16 +: 16]  = ocfg[i];
        end
    end

    csel_bank #(.NUM_CH(NCH)) dut_i (
        .clk(clk), .rst_n(rst_n), .base_cfg(base_cfg), .opt_cfg(opt_cfg),
        .addr(addr), .rd_wr(rd_wr), .upper_en(upper_en), .lower_en(lower_en),
        .space(space), .as_n(as_n), .ds_n(ds_n), .cs_n(cs_n),
        .dsack_n(dsack_n), .avec_n(avec_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input logic [1:0] lane, input logic [1:0] dir,
                                       input logic ds, input logic [3:0] w,
                                       input logic [1:0] sp, input logic [2:0] ipl,
                                       input logic av);
        return {1'b0, lane, dir, ds, w, sp, ipl, av};
    endfunction

    task automatic clear_cfg();
        for (int i = 0; i < NCH; i++) begin
            bcfg[i] = '0;
            ocfg[i] = '0;
        end
    endtask

    // Drive a cycle at the falling edge, settle, and leave strobes applied
    task automatic drive(input logic [23:0] a, input logic rd, input logic up,
                         input logic lo, input logic [1:0] sp, input logic as, input logic ds);
        @(negedge clk);
        addr = a; rd_wr = rd; upper_en = up; lower_en = lo; space = sp;
        as_n = as; ds_n = ds;
        #2;
    endtask

    task automatic idle();
        @(negedge clk);
        as_n = 1'b1; ds_n = 1'b1;
        #2;
    endtask

    // Count rising edges until dsack_n falls, up to a limit
    task automatic count_edges(output int n);
        n = 0;
        for (int k = 0; k < 20; k++) begin
            @(posedge clk); #2;
            n++;
            if (!dsack_n) break;
        end
    endtask

    task automatic t_reset();
        check("R12 cs_n in reset", cs_n, 4'hF);
        check("R12 dsack_n in reset", dsack_n, 1'b1);
        check("R12 avec_n in reset", avec_n, 1'b1);
    endtask

    task automatic t_window();
        clear_cfg();
        bcfg[0] = 16'hFE02;
        ocfg[0] = mk(2'b11, 2'b11, 1'b0, 4'd15, 2'b11, 3'd0, 1'b0);
        drive(24'hFE0000, 1, 1, 1, 2'b10, 0, 0); check("R1 16K base", cs_n[0], 1'b0);
        drive(24'hFE3FFF, 1, 1, 1, 2'b10, 0, 0); check("R1 16K top", cs_n[0], 1'b0);
        drive(24'hFE4000, 1, 1, 1, 2'b10, 0, 0); check("R1 16K above", cs_n[0], 1'b1);
        drive(24'hFDFFFF, 1, 1, 1, 2'b10, 0, 0); check("R1 16K below", cs_n[0], 1'b1);
        bcfg[0] = 16'h0005;
        drive(24'h03FFFF, 1, 1, 1, 2'b10, 0, 0); check("R1 256K top", cs_n[0], 1'b0);
        drive(24'h040000, 1, 1, 1, 2'b10, 0, 0); check("R1 256K above", cs_n[0], 1'b1);
        bcfg[0] = 16'h0500;
        drive(24'h0507FF, 1, 1, 1, 2'b10, 0, 0); check("R1 2K top", cs_n[0], 1'b0);
        drive(24'h050800, 1, 1, 1, 2'b10, 0, 0); check("R1 2K above", cs_n[0], 1'b1);
        bcfg[0] = 16'h0007;
        drive(24'h0FFFFF, 1, 1, 1, 2'b10, 0, 0); check("R1 1M top", cs_n[0], 1'b0);
        drive(24'h100000, 1, 1, 1, 2'b10, 0, 0); check("R1 1M above", cs_n[0], 1'b1);
        idle();
    endtask

    task automatic t_disable();
        clear_cfg();
        bcfg[1] = 16'h0005;
        drive(24'h000100, 1, 1, 1, 2'b10, 0, 0);
        check("R2 zero option silent", cs_n, 4'hF);
        idle();
    endtask

    task automatic t_lane();
        clear_cfg();
        bcfg[0] = 16'h0005;
        ocfg[0] = mk(2'b01, 2'b11, 1'b0, 4'd15, 2'b11, 3'd0, 1'b0);
        drive(24'h000100, 1, 1, 0, 2'b10, 0, 0); check("R3 lower-only vs upper", cs_n[0], 1'b1);
        drive(24'h000100, 1, 0, 1, 2'b10, 0, 0); check("R3 lower-only vs lower", cs_n[0], 1'b0);
        ocfg[0] = mk(2'b10, 2'b11, 1'b0, 4'd15, 2'b11, 3'd0, 1'b0);
        drive(24'h000100, 1, 0, 1, 2'b10, 0, 0); check("R3 upper-only vs lower", cs_n[0], 1'b1);
        drive(24'h000100, 1, 1, 1, 2'b10, 0, 0); check("R3 upper-only vs word", cs_n[0], 1'b0);
        idle();
    endtask

    task automatic t_dir();
        clear_cfg();
        bcfg[0] = 16'h0005;
        ocfg[0] = mk(2'b11, 2'b10, 1'b0, 4'd15, 2'b11, 3'd0, 1'b0);
        drive(24'h000200, 1, 1, 1, 2'b10, 0, 0); check("R4 write-only on read", cs_n[0], 1'b1);
        drive(24'h000200, 0, 1, 1, 2'b10, 0, 0); check("R4 write-only on write", cs_n[0], 1'b0);
        ocfg[0] = mk(2'b11, 2'b01, 1'b0, 4'd15, 2'b11, 3'd0, 1'b0);
        drive(24'h000200, 0, 1, 1, 2'b10, 0, 0); check("R4 read-only on write", cs_n[0], 1'b1);
        idle();
    endtask

    task automatic t_strobe();
        clear_cfg();
        bcfg[0] = 16'h0005;
        bcfg[1] = 16'h0005;
        ocfg[0] = mk(2'b11, 2'b11, 1'b1, 4'd15, 2'b11, 3'd0, 1'b0);
        ocfg[1] = mk(2'b11, 2'b11, 1'b0, 4'd15, 2'b11, 3'd0, 1'b0);
        drive(24'h000300, 1, 1, 1, 2'b10, 0, 1);
        check("R5 ds-timed waits for ds", cs_n[0], 1'b1);
        check("R5 as-timed follows as", cs_n[1], 1'b0);
        drive(24'h000300, 1, 1, 1, 2'b10, 0, 0);
        check("R5 ds-timed with ds", cs_n[0], 1'b0);
        idle();
    endtask

    task automatic t_wait(input logic [3:0] w);
        int n;
        clear_cfg();
        bcfg[0] = 16'h0500;
        ocfg[0] = mk(2'b11, 2'b11, 1'b0, w, 2'b11, 3'd0, 1'b0);
        drive(24'h050010, 1, 1, 1, 2'b10, 0, 0);
        check("R6 no ack before first edge", dsack_n, 1'b1);
        count_edges(n);
        check("R6 ack edge count", n, w + 1);
        @(posedge clk); #2;
        check("R6 ack held in strobe", dsack_n, 1'b0);
        idle();
        check("R6 ack released with strobe", dsack_n, 1'b1);
    endtask

    task automatic t_fast();
        clear_cfg();
        bcfg[0] = 16'h0500;
        ocfg[0] = mk(2'b11, 2'b11, 1'b0, 4'd14, 2'b11, 3'd0, 1'b0);
        drive(24'h050020, 1, 1, 1, 2'b10, 0, 0);
        check("R7 fast ack same cycle", dsack_n, 1'b0);
        idle();
    endtask

    task automatic t_ext();
        clear_cfg();
        bcfg[0] = 16'h0500;
        ocfg[0] = mk(2'b11, 2'b11, 1'b0, 4'd15, 2'b11, 3'd0, 1'b0);
        drive(24'h050020, 1, 1, 1, 2'b10, 0, 0);
        repeat (18) @(posedge clk);
        #2;
        check("R8 external code no ack", dsack_n, 1'b1);
        check("R8 external code still selects", cs_n[0], 1'b0);
        idle();
    endtask

    task automatic t_space();
        clear_cfg();
        bcfg[0] = 16'h0005;
        ocfg[0] = mk(2'b11, 2'b11, 1'b0, 4'd15, 2'b01, 3'd0, 1'b0);
        drive(24'h000400, 1, 1, 1, 2'b10, 0, 0); check("R9 user-only vs supervisor", cs_n[0], 1'b1);
        drive(24'h000400, 1, 1, 1, 2'b01, 0, 0); check("R9 user-only vs user", cs_n[0], 1'b0);
        ocfg[0] = mk(2'b11, 2'b11, 1'b0, 4'd15, 2'b11, 3'd0, 1'b0);
        drive(24'h000400, 1, 1, 1, 2'b00, 0, 0); check("R9 data channel vs CPU space", cs_n[0], 1'b1);
        idle();
    endtask

    task automatic t_cpu();
        clear_cfg();
        bcfg[0] = 16'hFFF8;
        ocfg[0] = mk(2'b01, 2'b01, 1'b0, 4'd0, 2'b00, 3'd3, 1'b1);
        drive(24'hFFF806, 1, 0, 1, 2'b00, 0, 0);
        check("R10 level 3 matches", cs_n[0], 1'b0);
        check("R10 autovector requested", avec_n, 1'b0);
        drive(24'hFFF804, 1, 0, 1, 2'b00, 0, 0);
        check("R10 level 2 rejected", cs_n[0], 1'b1);
        check("R10 no autovector on miss", avec_n, 1'b1);
        ocfg[0] = mk(2'b01, 2'b01, 1'b0, 4'd0, 2'b00, 3'd0, 1'b0);
        drive(24'hFFF80A, 1, 0, 1, 2'b00, 0, 0);
        check("R10 any level matches 5", cs_n[0], 1'b0);
        check("R10 avec bit clear", avec_n, 1'b1);
        idle();
        check("R10 autovector gone after strobe", avec_n, 1'b1);
    endtask

    task automatic t_multi();
        int n;
        clear_cfg();
        bcfg[0] = 16'h0500;
        bcfg[1] = 16'h0500;
        ocfg[0] = mk(2'b11, 2'b11, 1'b0, 4'd3, 2'b11, 3'd0, 1'b0);
        ocfg[1] = mk(2'b11, 2'b11, 1'b0, 4'd0, 2'b11, 3'd0, 1'b0);
        drive(24'h050040, 1, 1, 1, 2'b10, 0, 0);
        check("R11 both selects asserted", cs_n, 4'hC);
        count_edges(n);
        check("R11 ack timed by channel 0", n, 4);
        idle();
    endtask

    initial begin
        clear_cfg();
        repeat (3) @(posedge clk);
        #2;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_window();
        t_disable();
        t_lane();
        t_dir();
        t_strobe();
        t_wait(4'd0);
        t_wait(4'd1);
        t_wait(4'd3);
        t_wait(4'd13);
        t_fast();
        t_ext();
        t_space();
        t_cpu();
        t_multi();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule